// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches a port of general-purpose pad inputs and turns selected signal transitions into a single interrupt request. Each pad input first passes through a synchronizer chain. The block then compares the synchronized value with a copy registered one cycle earlier to find edges. When a pin sees a rising edge with its rising enable set, or a falling edge with its falling enable set, the block latches a cause bit for that pin. Setting both enables makes the pin sensitive to both edges.

Latched causes are combined with a per-pin event mask, and the interrupt output is the OR of the masked causes. The output can therefore be wired onto a line shared with other sources. Software reads the masked causes to find which pins need service. It acknowledges them by writing ones to a separate clear register. Causes latch even on pins whose mask bit is clear, so software clears any stale cause before it unmasks a pin.

All registers sit on a simple single-cycle bus with a select, a write strobe, a byte address and 32-bit data. Read data is combinational from the current register state.

Top module: `gpio_edge_cause`

## Requirements
- R1: After reset, the rising enables, falling enables, event mask and causes are all zero, every register reads zero and `irq_o` is low.
- R2: The rising-enable register at address 0x44, the falling-enable register at 0x48 and the event-mask register at 0x94 take the value written to them and read it back. Bit i of each register belongs to pin i.
- R3: A 0-to-1 change on `pad_i[i]` while rising enable bit i is set latches cause bit i exactly SYNC_STAGES+1 rising clock edges after the pad change, and not one edge sooner.
- R4: A 1-to-0 change on `pad_i[i]` while falling enable bit i is set latches cause bit i.
- R5: A pin with both enables set latches a cause on either edge. A pin with neither enable set never latches a cause.
- R6: Reading 0x80 returns the cause bits ANDed with the event mask. Reading 0x98 returns the raw cause bits.
- R7: Writing to 0x98 clears every cause bit whose data bit is 1 and leaves bits written with 0 unchanged. A cause bit stays set until it is cleared this way.
- R8: When an enabled edge on a pin and a clear of that pin's cause bit fall on the same clock edge, the cause bit ends up set.
- R9: Cause bits latch whatever the event mask holds. `irq_o` is high exactly while at least one cause bit is set whose event-mask bit is also set.
- R10: Register bits above NPINS-1 read as zero. Reading an unmapped address returns zero. Writes to the masked-cause address 0x80 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NPINS | Raw pad inputs, synchronized inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, zero when not selected |
| irq_o | output | 1 | OR of the masked causes |

## Verification
The bench builds the block with NPINS=12 and SYNC_STAGES=3. Twelve pins keep a sweep over every pin and every rising/falling enable combination short. A three-stage synchronizer makes the four-edge latency of R3 observable edge by edge. A pin count below the 32-bit bus width exposes the zero upper bits of R10. With that size, every pin can be tried with each enable pair under an alternating mask. The bench also checks multi-pin patterns whose expected causes it derives from the old and new pad words, and it lines up a clear on the exact edge where a cause latches.

// File: rtl/gec_pkg.sv
package gec_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_RISE_EN  = 8'h44;
  localparam logic [ADDR_W-1:0] A_FALL_EN  = 8'h48;
  localparam logic [ADDR_W-1:0] A_MCAUSE   = 8'h80;
  localparam logic [ADDR_W-1:0] A_EVT_MASK = 8'h94;
  localparam logic [ADDR_W-1:0] A_CAUSE    = 8'h98;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_RISE,
    RS_FALL,
    RS_MCAUSE,
    RS_MASK,
    RS_CAUSE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      A_RISE_EN:  decode_addr = RS_RISE;
      A_FALL_EN:  decode_addr = RS_FALL;
      A_MCAUSE:   decode_addr = RS_MCAUSE;
      A_EVT_MASK: decode_addr = RS_MASK;
      A_CAUSE:    decode_addr = RS_CAUSE;
      default:    decode_addr = RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gec_sync.sv
module gec_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_rest
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gec_edge.sv
module gec_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] cause_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] cause_q, cause_d;
  logic [W-1:0] rise_seen, fall_seen;
  logic         cause_en;

  always_comb begin
    rise_seen = sync_i & ~prev_q;
    fall_seen = ~sync_i & prev_q;
    hit_o     = (rise_seen & rise_en_i) | (fall_seen & fall_en_i);
    cause_en  = (|hit_o) | (|clr_i);
    cause_d   = (cause_q & ~clr_i) | hit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/gec_regs.sv
module gec_regs
  import gec_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [W-1:0]      cause_i,
  output logic [W-1:0]      rise_en_o,
  output logic [W-1:0]      fall_en_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o,
  output logic [DW-1:0]     rdata_o
);

  reg_sel_e     rsel;
  logic         wen_rise, wen_fall, wen_mask;
  logic [W-1:0] rise_q, fall_q, mask_q;
  logic [W-1:0] wbits;
  logic [W-1:0] rd_val;

  always_comb begin
    rsel     = decode_addr(addr_i);
    wbits    = wdata_i[W-1:0];
    wen_rise = sel_i & wr_i & (rsel == RS_RISE);
    wen_fall = sel_i & wr_i & (rsel == RS_FALL);
    wen_mask = sel_i & wr_i & (rsel == RS_MASK);
    clr_o    = (sel_i & wr_i & (rsel == RS_CAUSE)) ? wbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rise_q <= '0;
    else if (wen_rise) rise_q <= wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fall_q <= '0;
    else if (wen_fall) fall_q <= wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (wen_mask) mask_q <= wbits;
  end

  always_comb begin
    case (rsel)
      RS_RISE:   rd_val = rise_q;
      RS_FALL:   rd_val = fall_q;
      RS_MASK:   rd_val = mask_q;
      RS_MCAUSE: rd_val = cause_i & mask_q;
      RS_CAUSE:  rd_val = cause_i;
      default:   rd_val = '0;
    endcase
    rdata_o = '0;
    if (sel_i && !wr_i) rdata_o[W-1:0] = rd_val;
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign mask_o    = mask_q;

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause
  import gec_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pad_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);

  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] rise_en, fall_en, evt_mask;
  logic [NPINS-1:0] clr_mask, edge_hit, cause_q;

  gec_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  gec_edge #(.W(NPINS)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (pad_sync),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .clr_i     (clr_mask),
    .hit_o     (edge_hit),
    .cause_o   (cause_q)
  );

  gec_regs #(.W(NPINS), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (bus_sel),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .cause_i   (cause_q),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .mask_o    (evt_mask),
    .clr_o     (clr_mask),
    .rdata_o   (bus_rdata)
  );

  assign irq_o = |(cause_q & evt_mask);

endmodule

// File: rtl/gec_chk.sv
module gec_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NPINS-1:0] evt_mask,
  input logic [NPINS-1:0] cause,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] clr
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (cause == '0 && evt_mask == '0 && !irq); // R1
    end
  end

  AST_NO_SPURIOUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(hit)) == '0)); // R3

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cause) & ~$past(clr) & ~cause) == '0)); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr) & ~$past(hit) & cause) == '0)); // R7

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~cause) == '0)); // R8

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_mask != '0)); // R9

endmodule

bind gpio_edge_cause gec_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq_o),
  .evt_mask (evt_mask),
  .cause    (cause_q),
  .hit      (edge_hit),
  .clr      (clr_mask)
);

// File: tb/sim_gpio_edge_cause.sv
module sim_gpio_edge_cause;

  localparam int NP  = 12;
  localparam int SS  = 3;
  localparam int LAT = SS + 1;
  localparam logic [31:0] PMASK = (32'd1 << NP) - 32'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NP-1:0] pad = '0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_cause #(.NPINS(NP), .DW(32), .SYNC_STAGES(SS)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  initial begin
    logic [31:0] exp_cause, old_pad, new_pad, rmsk, fmsk, emsk;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    expect_reg("R1 rise", 8'h44, 0);
    expect_reg("R1 fall", 8'h48, 0);
    expect_reg("R1 mask", 8'h94, 0);
    expect_reg("R1 mcause", 8'h80, 0);
    expect_reg("R1 cause", 8'h98, 0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    bus_write(8'h44, 32'hFFFF_F5A5);
    bus_write(8'h48, 32'h0000_0C3C);
    bus_write(8'h94, 32'hABCD_E0F0);
    expect_reg("R2 rise readback", 8'h44, 32'hFFFF_F5A5 & PMASK);
    expect_reg("R2 fall readback", 8'h48, 32'h0000_0C3C);
    expect_reg("R10 mask upper bits", 8'h94, 32'h0000_00F0);
    bus_write(8'h80, 32'hFFFF_FFFF);
    expect_reg("R10 write to 0x80 ignored", 8'h98, 0);
    expect_reg("R10 unmapped", 8'h00, 0);
    expect_reg("R10 unmapped 0x4C", 8'h4C, 0);
    bus_write(8'h44, 0);
    bus_write(8'h48, 0);
    bus_write(8'h94, 0);

    // R3 latency: pin 5 rising edge
    bus_write(8'h44, 32'h20);
    @(negedge clk);
    pad[5] = 1'b1;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R3 not before latency", {31'd0, u0.bus_rdata == 32'd0 ? 1'b0 : 1'b1}, 32'd0);
    sel = 1'b1; wr = 1'b0; addr = 8'h98;
    #1 check("R3 one edge early", rdata, 32'd0);
    sel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = 8'h98;
    #1 check("R3 latched at latency", rdata, 32'h20);
    sel = 1'b0;
    check("R9 unmasked no irq", {31'd0, irq}, 32'd0);
    bus_write(8'h98, 32'h20);
    expect_reg("R7 cleared", 8'h98, 0);
    pad[5] = 1'b0;
    settle();
    bus_write(8'h44, 0);

    // Sweep every pin with every enable pair
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bitp, em, v;
        bitp = 32'd1 << p;
        em   = ((p + m) % 2 == 1) ? bitp : 32'd0;
        bus_write(8'h44, m[0] ? bitp : 0);
        bus_write(8'h48, m[1] ? bitp : 0);
        bus_write(8'h94, em);
        @(negedge clk);
        pad[p] = 1'b1;
        settle();
        exp_cause = m[0] ? bitp : 0;
        bus_read(8'h98, v);
        check(m[0] ? "R3 rise latch" : "R5 rise ignored", v, exp_cause);
        bus_read(8'h80, v);
        check("R6 masked read", v, exp_cause & em);
        check("R9 irq after rise", {31'd0, irq}, {31'd0, |(exp_cause & em)});
        bus_write(8'h98, bitp);
        expect_reg("R7 clear after rise", 8'h98, 0);
        check("R9 irq low after clear", {31'd0, irq}, 32'd0);
        pad[p] = 1'b0;
        settle();
        exp_cause = m[1] ? bitp : 0;
        bus_read(8'h98, v);
        check(m[1] ? "R4 fall latch" : "R5 fall ignored", v, exp_cause);
        check("R9 irq after fall", {31'd0, irq}, {31'd0, |(exp_cause & em)});
        bus_write(8'h98, PMASK);
      end
    end

    // Multi-pin patterns
    rmsk = 32'h0A5; fmsk = 32'h3C3; emsk = 32'hF0F;
    bus_write(8'h44, rmsk);
    bus_write(8'h48, fmsk);
    bus_write(8'h94, emsk);
    old_pad = 0; new_pad = 32'h6B9;
    @(negedge clk);
    pad = new_pad[NP-1:0];
    settle();
    exp_cause = new_pad & ~old_pad & rmsk;
    expect_reg("R5 multi rise", 8'h98, exp_cause);
    old_pad = new_pad; new_pad = 32'h14C;
    pad = new_pad[NP-1:0];
    settle();
    exp_cause = exp_cause | (new_pad & ~old_pad & rmsk) | (old_pad & ~new_pad & fmsk);
    expect_reg("R5 multi both", 8'h98, exp_cause);
    expect_reg("R6 multi masked", 8'h80, exp_cause & emsk);
    check("R9 multi irq", {31'd0, irq}, {31'd0, |(exp_cause & emsk)});
    bus_write(8'h98, 32'h00F);
    exp_cause = exp_cause & ~32'h00F;
    expect_reg("R7 partial clear", 8'h98, exp_cause);
    bus_write(8'h98, PMASK);
    expect_reg("R7 full clear", 8'h98, 0);
    @(negedge clk);
    pad = '0;
    settle();
    bus_write(8'h98, PMASK);

    // R8: clear lands on the edge where the cause latches; pin 1 holds a set cause
    bus_write(8'h44, 32'h003);
    bus_write(8'h48, 32'h000);
    @(negedge clk);
    pad[1] = 1'b1;
    settle();
    expect_reg("R3 pin1 set", 8'h98, 32'h002);
    @(negedge clk);
    pad[0] = 1'b1;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 8'h98; wdata = 32'h003;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    expect_reg("R8 edge beats clear", 8'h98, 32'h001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule